// File: doc/BRIEF.md
# Chained Block-Readout FIFO Port

This block is the readout side of a data acquisition module. A bus controller reads it in block-transfer mode. Each module in the crate owns a 64 KiB address window whose base is its position number shifted left by 16. Every read that lands anywhere inside the window pops the next word of the current accepted event. The first word is a header that carries the number of data words. The data words follow in memory order.

Several modules are read one after another in a chain. On the final word of an event, the port raises one of two end-of-data interrupt lines. The level-6 line tells the controller to add 0x10000 to its address and read the next module. The level-7 line tells it the event is complete across the chain. A configuration input selects which of the two lines this module uses.

When the final word leaves, the port pulses a completion strobe so that the acquisition side can free the event's memory. Reads made while no accepted event is offered return a fixed filler word and raise no interrupt.

Top module: `chain_readout_port`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_valid, irq_lvl6, irq_lvl7 and evt_done are all low.
- R2: A read is served only when bus_addr[31:16] equals slot_id. A read outside the window produces no rd_valid and does not advance the word sequence.
- R3: A served read produces rd_valid with its word on the clock edge that samples the read, so the word is visible one cycle later. rd_valid is low in every cycle that follows no served read.
- R4: The first word of an event is the header {8'hE7, 8'h00, evt_len[15:0]}, where evt_len is the number of data words that follow.
- R5: After the header, data words come out in the order memory index 0, 1, … evt_len-1. The port presents the index on mem_addr and returns mem_data unchanged.
- R6: Only the final word of an event raises an interrupt. It raises irq_lvl7 when last_module is 1 and irq_lvl6 when it is 0. The two lines are never high together, and they are high only together with rd_valid.
- R7: evt_done is a one-cycle pulse in the same cycle as the final word's rd_valid.
- R8: A served read while evt_ready is low returns 32'h0BADF00D with no interrupt, and it does not consume any word of a later event.
- R9: After an event completes, reads return the filler word until evt_ready has gone low and risen again.
- R10: An event with evt_len = 0 consists of the header alone, and that header carries the end-of-data interrupt and evt_done.
- R11: Address bits 15:0 do not affect which word is returned.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 16 | Module position; the window base is slot_id << 16 |
| last_module | input | 1 | 1: end-of-data is signalled on level 7; 0: on level 6 |
| bus_rd | input | 1 | Single-cycle read strobe from the controller |
| bus_addr | input | 32 | Read address |
| evt_ready | input | 1 | Level: an accepted, fully acquired event is offered |
| evt_len | input | 16 | Data word count of the offered event (held while evt_ready) |
| mem_addr | output | 16 | Index of the data word wanted from event memory |
| mem_data | input | 32 | Event memory word at mem_addr (combinational) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response word |
| irq_lvl6 | output | 1 | End of data, continue with the next module |
| irq_lvl7 | output | 1 | End of data, last module of the event |
| evt_done | output | 1 | Final word delivered; event memory may be freed |

## Verification
The assertions assume three things about the inputs. bus_rd is a single-cycle strobe. evt_len stays stable while evt_ready is high. The producer keeps evt_ready high until it sees evt_done and lowers it afterwards. The bench changes evt_len and last_module only while evt_ready is low. It issues each read as a one-cycle pulse between idle cycles, and it lowers evt_ready itself after each completion, so the stimulus never leaves the handshake the checks rely on.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  localparam logic [7:0] HDR_MARK = 8'hE7;

  typedef enum logic [1:0] {
    S_WAIT  = 2'd0,
    S_SEND  = 2'd1,
    S_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rdport_addr_dec.sv
module rdport_addr_dec #(
  parameter int AW       = 32,
  parameter int WIN_BITS = 16,
  localparam int SEL_W   = AW - WIN_BITS
) (
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [SEL_W-1:0] slot_id,
  output logic             hit_rd
);
  localparam logic [AW-1:0] OFS_MASK = (AW'(1) << WIN_BITS) - AW'(1);

  function automatic logic [AW-1:0] window_base(input logic [SEL_W-1:0] slot);
    return {slot, {WIN_BITS{1'b0}}};
  endfunction

  logic [AW-1:0] addr_base;
  assign addr_base = bus_addr & ~OFS_MASK;
  assign hit_rd    = bus_rd && (addr_base == window_base(slot_id));
endmodule

// File: rtl/rdport_seq.sv
module rdport_seq
  import rdport_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_rd,
  input  logic          evt_ready,
  input  logic [LW-1:0] evt_len,
  output logic [LW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic          serve_o,
  output logic [DW-1:0] word_o,
  output logic          last_o,
  output logic          done_o
);
  localparam int PAD_W = DW - 8 - LW;

  function automatic logic [DW-1:0] make_header(input logic [LW-1:0] n);
    return {HDR_MARK, {PAD_W{1'b0}}, n};
  endfunction

  seq_state_t    state;
  logic [LW-1:0] idx;
  logic          at_last;
  logic          take;

  assign serve_o  = (state == S_SEND);
  assign at_last  = (idx == evt_len);
  assign take     = hit_rd && serve_o;
  assign last_o   = at_last;
  assign done_o   = take && at_last;
  assign mem_addr = idx - LW'(1);
  assign word_o   = (idx == '0) ? make_header(evt_len) : mem_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      idx   <= '0;
    end else begin
      case (state)
        S_WAIT: begin
          idx <= '0;
          if (evt_ready) state <= S_SEND;
        end
        S_SEND: begin
          if (take) begin
            if (at_last) state <= S_DRAIN;
            else         idx   <= idx + LW'(1);
          end
        end
        S_DRAIN: begin
          if (!evt_ready) state <= S_WAIT;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    serve_o |-> (idx <= evt_len)); // R5
  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN) |-> !done_o); // R9
  AST_DONE_LEAVES_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (state == S_DRAIN)); // R7
endmodule

// File: rtl/chain_readout_port.sv
module chain_readout_port #(
  parameter int          DW        = 32,
  parameter int          LW        = 16,
  parameter int          AW        = 32,
  parameter int          WIN_BITS  = 16,
  parameter logic [31:0] FILL_WORD = 32'h0BADF00D,
  localparam int         SEL_W     = AW - WIN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] slot_id,
  input  logic             last_module,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic             evt_ready,
  input  logic [LW-1:0]    evt_len,
  output logic [LW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_data,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             irq_lvl6,
  output logic             irq_lvl7,
  output logic             evt_done
);
  logic          hit_rd;
  logic          serve;
  logic [DW-1:0] seq_word;
  logic          seq_last;
  logic          seq_done;
  logic          end_of_data;

  rdport_addr_dec #(.AW(AW), .WIN_BITS(WIN_BITS)) dec_i (
    .bus_rd(bus_rd), .bus_addr(bus_addr), .slot_id(slot_id), .hit_rd(hit_rd)
  );

  rdport_seq #(.DW(DW), .LW(LW)) seq_i (
    .clk(clk), .rst_n(rst_n), .hit_rd(hit_rd), .evt_ready(evt_ready),
    .evt_len(evt_len), .mem_addr(mem_addr), .mem_data(mem_data),
    .serve_o(serve), .word_o(seq_word), .last_o(seq_last), .done_o(seq_done)
  );

  assign end_of_data = hit_rd && serve && seq_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq_lvl6 <= 1'b0;
      irq_lvl7 <= 1'b0;
      evt_done <= 1'b0;
    end else begin
      rd_valid <= hit_rd;
      if (hit_rd) rd_data <= serve ? seq_word : DW'(FILL_WORD);
      irq_lvl6 <= end_of_data && !last_module;
      irq_lvl7 <= end_of_data && last_module;
      evt_done <= seq_done;
    end
  end

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({irq_lvl6, irq_lvl7}) <= 1); // R6
  AST_IRQ_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl6 || irq_lvl7) |-> rd_valid); // R6
  AST_DONE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (irq_lvl6 || irq_lvl7)); // R7
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[AW-1:WIN_BITS] != slot_id)) |=> !rd_valid); // R2
  AST_ONE_CYCLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid); // R3
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> !(irq_lvl6 || irq_lvl7)); // R8
endmodule

// File: tb/chain_readout_port_tb.sv
`timescale 1ns/1ps
module chain_readout_port_tb_top;
  localparam logic [31:0] FILL = 32'h0BADF00D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] slot_id = 16'd2;
  logic        last_module = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        evt_ready = 1'b0;
  logic [15:0] evt_len = '0;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic        rd_valid, irq_lvl6, irq_lvl7, evt_done;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign mem_data = {16'hC0DE, 16'(mem_addr * 16'd3 + 16'd1)};

  chain_readout_port dut_i (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .last_module(last_module),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .evt_ready(evt_ready),
    .evt_len(evt_len), .mem_addr(mem_addr), .mem_data(mem_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_lvl6(irq_lvl6),
    .irq_lvl7(irq_lvl7), .evt_done(evt_done)
  );

  function automatic logic [31:0] hdr(input logic [15:0] n);
    return {8'hE7, 8'h00, n};
  endfunction

  function automatic logic [31:0] dword(input int i);
    return {16'hC0DE, 16'(i * 3 + 1)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk);
    bus_rd = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // {addr, valid, data, irq6, irq7, done}
  localparam int NV = 7;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0001_0000, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0},
    {32'h0002_0000, 1'b1, 32'hE700_0003, 1'b0, 1'b0, 1'b0},
    {32'h0002_0004, 1'b1, 32'hC0DE_0001, 1'b0, 1'b0, 1'b0},
    {32'h0002_FFFC, 1'b1, 32'hC0DE_0004, 1'b0, 1'b0, 1'b0},
    {32'h0003_0000, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0},
    {32'h0002_0000, 1'b1, 32'hC0DE_0007, 1'b1, 1'b0, 1'b1},
    {32'h0002_8000, 1'b1, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    chk("R1 irqs in reset", 32'({irq_lvl6, irq_lvl7, evt_done}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", 32'({rd_valid, irq_lvl6, irq_lvl7, evt_done}), 32'd0);

    // R8: no event offered
    rd(32'h0002_0000);
    chk("R8 filler valid", 32'(rd_valid), 32'd1);
    chk("R8 filler word", rd_data, FILL);
    chk("R8 no irq", 32'({irq_lvl6, irq_lvl7, evt_done}), 32'd0);
    rd(32'h0002_0010);
    chk("R8 filler again", rd_data, FILL);

    // vector table: event of 3 words, level 6
    evt_len = 16'd3;
    last_module = 1'b0;
    evt_ready = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][67:36]);
      chk($sformatf("R2 R3 valid vec%0d", i), 32'(rd_valid), 32'(VEC[i][35]));
      if (VEC[i][35])
        chk($sformatf("R4 R5 R9 R11 data vec%0d", i), rd_data, VEC[i][34:3]);
      chk($sformatf("R6 irq6 vec%0d", i), 32'(irq_lvl6), 32'(VEC[i][2]));
      chk($sformatf("R6 irq7 vec%0d", i), 32'(irq_lvl7), 32'(VEC[i][1]));
      chk($sformatf("R7 done vec%0d", i), 32'(evt_done), 32'(VEC[i][0]));
    end
    @(negedge clk);
    chk("R3 no read no valid", 32'(rd_valid), 32'd0);
    chk("R7 done one cycle", 32'(evt_done), 32'd0);

    // R9: re-arm, new event of 2 words
    evt_ready = 1'b0;
    repeat (2) @(negedge clk);
    evt_len = 16'd2;
    evt_ready = 1'b1;
    repeat (2) @(negedge clk);
    rd(32'h0002_1234);
    chk("R9 R4 new header", rd_data, hdr(16'd2));
    rd(32'h0002_0000);
    chk("R5 data0", rd_data, dword(0));
    rd(32'h0002_0000);
    chk("R5 data1", rd_data, dword(1));
    chk("R6 last irq6", 32'({irq_lvl6, irq_lvl7}), 32'b10);

    // R10 + R6: zero-length event on the final module
    evt_ready = 1'b0;
    repeat (2) @(negedge clk);
    evt_len = 16'd0;
    last_module = 1'b1;
    evt_ready = 1'b1;
    repeat (2) @(negedge clk);
    rd(32'h0002_0000);
    chk("R10 header only", rd_data, hdr(16'd0));
    chk("R10 R6 irq7", 32'({irq_lvl6, irq_lvl7}), 32'b01);
    chk("R10 R7 done", 32'(evt_done), 32'd1);
    rd(32'h0002_0000);
    chk("R9 filler after done", rd_data, FILL);
    chk("R9 no irq after done", 32'({irq_lvl6, irq_lvl7, evt_done}), 32'd0);

    // R2: miss while event pending does not advance
    evt_ready = 1'b0;
    repeat (2) @(negedge clk);
    evt_len = 16'd1;
    last_module = 1'b0;
    evt_ready = 1'b1;
    repeat (2) @(negedge clk);
    rd(32'h0102_0000);
    chk("R2 miss high bits", 32'(rd_valid), 32'd0);
    rd(32'h0002_0000);
    chk("R2 header not skipped", rd_data, hdr(16'd1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule